// File: doc/BRIEF.md
# Embedded-Clock Word Serializer Framer

This block turns a parallel data word into a serial frame whose first and last bits carry the clock. It runs from a system clock and a bit-rate enable that pulses twelve times per word period. Each frame holds a start bit that is always 1, the ten data bits, and a stop bit that is always 0. The block derives the word clock from its own bit position and sends it out, so the word source can present data on it. A configuration input selects which edge of that word clock captures the data word.

Two sync request inputs are OR-ed together. While a request is active, the block sends sync symbols in place of data. Each sync symbol is six ones followed by six zeros, and every request produces a burst of at least a fixed minimum length. After reset, and again after leaving powerdown, the output stays undriven for a fixed number of word periods. An output enable can silence the line without disturbing the framing. The drive flag models the high-impedance state: when it is low the line counts as released, and the serial bit is forced to 0.

Top module: `ecw_framer`

## Requirements
- R1: A data frame is 12 bit slots sent in slot order 0 to 11: slot 0 is 1, slots 1 to 10 carry din bit 0 to din bit 9, and slot 11 is 0. The slot advances on each clock where bit_en is high.
- R2: wclk_o is high in slots 0 to 5 and low in slots 6 to 11. The slot counter is 0 after reset or powerdown.
- R3: A sync symbol drives 1 in slots 0 to 5 and 0 in slots 6 to 11. The din value has no effect on a sync symbol.
- R4: The block samples sync_req_a OR sync_req_b at each frame boundary. A boundary that sees a request starts, or restarts, a run of 1024 sync symbols. A single-boundary request therefore yields exactly 1024 symbols, and a request seen at N consecutive boundaries yields N+1023.
- R5: After reset, drv_o stays low for the first 510 frames (6120 bit slots). The first driven frame is frame 510.
- R6: When oe is low, drv_o is low, but framing continues. When oe returns high, output resumes at the current slot of the current frame.
- R7: With cap_rise high, a data frame carries din as sampled at the boundary clock that starts it. With cap_rise low, it carries din as sampled at the slot-5 bit_en clock of the preceding frame (the falling word clock edge).
- R8: While pwr_n is low, drv_o is low from the next clock onward and all framing state is cleared. After pwr_n returns high, the 510-frame holdoff runs again.
- R9: A request never cuts short a frame in progress. The frame during which the request rises completes as a data frame.
- R10: ser_o is 0 whenever drv_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable, one pulse per serial bit |
| pwr_n | input | 1 | Low = powerdown |
| oe | input | 1 | Output enable |
| cap_rise | input | 1 | 1 = capture word on the rising word clock edge, 0 = on the falling edge |
| sync_req_a | input | 1 | Sync request, first source |
| sync_req_b | input | 1 | Sync request, second source |
| din | input | 10 | Parallel data word |
| ser_o | output | 1 | Serial bit |
| drv_o | output | 1 | Line driven (low models high impedance) |
| wclk_o | output | 1 | Derived word clock |

## Verification
The bench uses random gaps in bit_en and random data, and compares every bit with a frame model built from the requirements. It times the holdoff to the exact slot: a counter that is off by one would drive frame 509 or frame 511 first, and it does this after reset and again after powerdown. It measures sync bursts from a one-boundary pulse and from a request held across several boundaries. A burst that is one symbol short, one too long, or that ignores the second request input shows up as a wrong burst length. It also raises a request in the middle of a frame, which exposes a design that truncates that frame. Finally, it changes din between the falling capture point and the boundary, so swapped capture edges give wrong payloads.

// File: rtl/ecw_framer.sv
module ecw_framer #(
  parameter int WORD_W   = 10,
  parameter int HOLDOFF  = 510,
  parameter int SYNC_MIN = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              pwr_n,
  input  logic              oe,
  input  logic              cap_rise,
  input  logic              sync_req_a,
  input  logic              sync_req_b,
  input  logic [WORD_W-1:0] din,
  output logic              ser_o,
  output logic              drv_o,
  output logic              wclk_o
);
  localparam int FRAME_W = WORD_W + 2;
  localparam int HALF    = FRAME_W / 2;
  localparam int SLOT_W  = $clog2(FRAME_W);
  localparam int HOLD_W  = $clog2(HOLDOFF + 1);
  localparam int SYNC_W  = $clog2(SYNC_MIN + 1);
  localparam logic [FRAME_W-1:0] SYNC_PAT = {{(FRAME_W-HALF){1'b0}}, {HALF{1'b1}}};

  logic [SLOT_W-1:0]  slot;
  logic [HOLD_W-1:0]  hold_cnt;
  logic               run;
  logic [SYNC_W-1:0]  sync_left;
  logic               sync_tx;
  logic [FRAME_W-1:0] frm;
  logic [WORD_W-1:0]  hold_word;

  logic               tick, req, use_sync;
  logic [SYNC_W-1:0]  next_left;
  logic [WORD_W-1:0]  word;

  assign tick      = bit_en && (slot == SLOT_W'(FRAME_W-1));
  assign req       = sync_req_a | sync_req_b;
  assign use_sync  = req || (sync_left != '0);
  assign next_left = req ? SYNC_W'(SYNC_MIN-1) : (sync_left != '0 ? sync_left - 1'b1 : '0);
  assign word      = cap_rise ? din : hold_word;

  assign drv_o  = run & oe;
  assign ser_o  = drv_o & frm[slot];
  assign wclk_o = slot < SLOT_W'(HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot      <= '0;
      hold_cnt  <= '0;
      run       <= 1'b0;
      sync_left <= '0;
      sync_tx   <= 1'b0;
      frm       <= '0;
      hold_word <= '0;
    end else if (!pwr_n) begin
      slot      <= '0;
      hold_cnt  <= '0;
      run       <= 1'b0;
      sync_left <= '0;
      sync_tx   <= 1'b0;
      frm       <= '0;
    end else begin
      if (bit_en)
        slot <= tick ? '0 : slot + 1'b1;
      if (bit_en && slot == SLOT_W'(HALF-1))
        hold_word <= din;
      if (tick) begin
        if (!run && hold_cnt != HOLD_W'(HOLDOFF-1)) begin
          hold_cnt <= hold_cnt + 1'b1;
        end else begin
          run       <= 1'b1;
          sync_tx   <= use_sync;
          sync_left <= next_left;
          frm       <= use_sync ? SYNC_PAT : {1'b0, word, 1'b1};
        end
      end
    end
  end
endmodule

module ecw_framer_chk #(
  parameter int FRAME_W = 12,
  parameter int SLOT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_n,
  input logic              bit_en,
  input logic              ser_o,
  input logic              drv_o,
  input logic              run,
  input logic              sync_tx,
  input logic [SLOT_W-1:0] slot
);
  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_o |-> !ser_o); // R10
  AST_START_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o && !sync_tx && slot == '0 |-> ser_o); // R1
  AST_STOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o && slot == SLOT_W'(FRAME_W-1) |-> !ser_o); // R1
  AST_SYNC_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o && sync_tx |-> ser_o == (slot < SLOT_W'(FRAME_W/2))); // R3
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_n && bit_en && slot != SLOT_W'(FRAME_W-1) |=> slot == $past(slot) + 1'b1); // R2
  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_n |=> !drv_o && slot == '0); // R8
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    run && pwr_n |=> run); // R5
endmodule

bind ecw_framer ecw_framer_chk #(.FRAME_W(FRAME_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .bit_en(bit_en), .ser_o(ser_o),
  .drv_o(drv_o), .run(run), .sync_tx(sync_tx), .slot(slot)
);

// File: tb/tb_ecw_framer.sv
module tb_ecw_framer;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 10;
  localparam int FW   = W + 2;
  localparam int HOLD = 510;
  localparam int SMIN = 1024;
  localparam logic [FW-1:0] SYNC = 12'b000000_111111;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, pwr_n = 1'b1, oe = 1'b1;
  logic cap_rise = 1'b1, sync_req_a = 1'b0, sync_req_b = 1'b0;
  logic [W-1:0] din = '0;
  logic ser_o, drv_o, wclk_o;

  ecw_framer dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pwr_n(pwr_n), .oe(oe),
    .cap_rise(cap_rise), .sync_req_a(sync_req_a), .sync_req_b(sync_req_b),
    .din(din), .ser_o(ser_o), .drv_o(drv_o), .wclk_o(wclk_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  int m_slot = 0, m_hold = 0, m_left = 0, bit_idx = 0, first_drv = -1;
  bit m_run = 1'b0, m_sync = 1'b0, last_tick = 1'b0, last_sync = 1'b0;
  logic [FW-1:0] m_frm = '0, obs = '0;
  logic [W-1:0]  m_hw = '0;
  int sync_run = 0, last_burst = -1;
  bit force_hi = 1'b0;

  function automatic logic [FW-1:0] data_frame(logic [W-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  function automatic logic [W-1:0] rnd_din(bit hi);
    logic [W-1:0] v = W'($urandom);
    return hi ? (v | 10'h200) : v;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_slot = 0; m_hold = 0; m_left = 0; m_run = 0; m_sync = 0;
    m_frm = '0; bit_idx = 0; first_drv = -1; sync_run = 0;
  endtask

  task automatic model_load();
    if (sync_req_a || sync_req_b || m_left > 0) begin
      m_frm = SYNC; m_sync = 1;
      m_left = (sync_req_a || sync_req_b) ? SMIN - 1 : m_left - 1;
    end else begin
      m_frm = data_frame(cap_rise ? din : m_hw); m_sync = 0;
    end
  endtask

  // called at a negedge with inputs other than bit_en already set
  task automatic step(bit be);
    logic exp_drv, exp_ser, exp_wclk;
    string tag;
    bit_en = be;
    #1;
    exp_drv  = m_run && oe;
    exp_ser  = exp_drv && m_frm[m_slot];
    exp_wclk = (m_slot < FW/2);
    if (!m_run) tag = "R5";
    else if (!oe) tag = "R6";
    else if (m_sync) tag = "R3";
    else if (!cap_rise) tag = "R7";
    else tag = "R1";
    chk(drv_o === exp_drv, tag, "drv_o", int'(drv_o), int'(exp_drv));
    chk(ser_o === exp_ser, (exp_drv ? tag : "R10"), "ser_o", int'(ser_o), int'(exp_ser));
    chk(wclk_o === exp_wclk, "R2", "wclk_o", int'(wclk_o), int'(exp_wclk));
    if (be && pwr_n && drv_o && first_drv < 0) first_drv = bit_idx;
    if (be && pwr_n && drv_o) begin
      obs[m_slot] = ser_o;
      if (m_slot == FW-1) begin
        last_sync = (obs == SYNC);
        if (last_sync) sync_run++;
        else if (sync_run > 0) begin last_burst = sync_run; sync_run = 0; end
      end
    end
    last_tick = be && pwr_n && (m_slot == FW-1);
    @(posedge clk);
    if (!pwr_n) model_clear();
    else if (be) begin
      bit_idx++;
      if (m_slot == FW/2 - 1) m_hw = din;
      if (m_slot == FW-1) begin
        m_slot = 0;
        if (!m_run) begin
          if (m_hold == HOLD-1) begin m_run = 1; model_load(); end
          else m_hold++;
        end else model_load();
      end else m_slot++;
    end
    @(negedge clk);
  endtask

  task automatic run_frames(int n, bit oe_rand);
    int t = 0;
    while (t < n) begin
      din = rnd_din(force_hi);
      if (oe_rand) oe = ($urandom % 8) != 0;
      step(($urandom % 4) != 0);
      if (last_tick) t++;
    end
    oe = 1'b1;
  endtask

  task automatic request(bit which, int nticks);
    int t = 0;
    while (m_slot != 4) begin din = rnd_din(force_hi); step(1'b1); end
    if (which) sync_req_b = 1'b1; else sync_req_a = 1'b1;
    while (t < nticks) begin
      din = rnd_din(force_hi);
      step(($urandom % 4) != 0);
      if (last_tick) begin
        if (t == 0) chk(!last_sync, "R9", "frame in progress at request was sync", int'(last_sync), 0);
        t++;
      end
    end
    sync_req_a = 1'b0; sync_req_b = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1b));
    repeat (3) @(negedge clk);
    chk(drv_o === 1'b0, "R5", "reset drv_o", int'(drv_o), 0);
    chk(ser_o === 1'b0, "R10", "reset ser_o", int'(ser_o), 0);
    chk(wclk_o === 1'b1, "R2", "reset wclk_o", int'(wclk_o), 1);
    rst_n = 1'b1;
    // holdoff
    run_frames(HOLD + 1, 1'b0);
    chk(first_drv == HOLD*FW, "R5", "first driven bit index", first_drv, HOLD*FW);
    // data with oe toggling
    run_frames(40, 1'b1);
    // single-boundary request on input a
    force_hi = 1'b1;
    last_burst = -1;
    request(1'b0, 1);
    run_frames(SMIN + 4, 1'b0);
    chk(last_burst == SMIN, "R4", "burst from one-boundary request", last_burst, SMIN);
    // request held on input b across 5 boundaries
    last_burst = -1;
    request(1'b1, 5);
    run_frames(SMIN + 4, 1'b0);
    chk(last_burst == SMIN + 4, "R4", "burst from held request", last_burst, SMIN + 4);
    force_hi = 1'b0;
    // falling-edge capture
    cap_rise = 1'b0;
    run_frames(60, 1'b0);
    cap_rise = 1'b1;
    // powerdown
    pwr_n = 1'b0;
    repeat (20) begin din = rnd_din(1'b0); step(1'b1); end
    chk(drv_o === 1'b0, "R8", "drv_o in powerdown", int'(drv_o), 0);
    chk(wclk_o === 1'b1, "R8", "wclk_o in powerdown (slot cleared)", int'(wclk_o), 1);
    pwr_n = 1'b1;
    run_frames(HOLD + 1, 1'b0);
    chk(first_drv == HOLD*FW, "R8", "first driven bit after powerdown", first_drv, HOLD*FW);
    run_frames(20, 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule